// File: doc/BRIEF.md
# Interrupt Vector Priority Resolver

The resolver holds a pending bit and an in-service bit for each of 256 interrupt vectors and chooses the one vector that should be delivered next. A request enters as a vector number with a valid strobe and sets that vector's pending bit. The chosen vector appears on a registered output. When the consumer takes it, an acknowledge pulse moves the vector from pending to in-service. When the handler finishes, an end-of-interrupt pulse retires the highest-priority vector still in service.

Priority has two tiers. The sixteen low vectors rank above every vector from 16 upward. Among the low vectors, vector 2 is the non-maskable request and ranks first, vector 0 (the legacy cascaded-controller request) ranks second, and 14 down to 1 follow. Vector 15 is never a real request. It is the code the output shows when nothing can be delivered. The vectors from 16 up have no fixed meaning: a larger number wins. These vectors are grouped into classes of sixteen by the upper four bits of the vector number. Such a vector is held back when its class does not exceed the mask threshold input, or does not exceed the class of the highest in-service vector.

Top module: `vec_prio_resolver`

## Requirements
- R1: After reset no vector is pending or in service and the output reads 15.
- R2: A pending vector from 1 to 14, or vector 0, is output ahead of any pending vector numbered 16 or above.
- R3: Among pending vectors numbered 16 to 255 the largest number is output.
- R4: Among the low vectors the order is vector 2, then vector 0, then 14 down to 1.
- R5: Pending vector 2 is output regardless of the mask threshold and of the in-service state.
- R6: A vector v of 16 or above is output only if v[7:4] is greater than the 4-bit mask threshold. If the best high vector fails this test and no low vector is pending, the output reads 15.
- R7: A vector v of 16 or above is also held back unless v[7:4] is greater than the class of the highest in-service vector. Any in-service vector below 16 holds back every vector of 16 or above.
- R8: An acknowledge clears the pending bit of the vector on the output and sets its in-service bit. An acknowledge while the output reads 15 changes nothing.
- R9: A set request and an acknowledge for the same vector in one cycle leave that vector pending, and it also becomes in-service.
- R10: An end-of-interrupt clears only the highest-priority in-service bit, using the same order as R2 to R4.
- R11: A set request for vector 15 is ignored.
- R12: The output is registered. A state change made at one clock edge shows on the output after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Strobe for a new request |
| setVec | input | 8 | Vector number to mark pending |
| maskClass | input | 4 | Mask threshold class |
| ack | input | 1 | Take the vector now on the output |
| eoi | input | 1 | Retire the highest in-service vector |
| curVec | output | 8 | Vector to deliver, or 15 when none |

## Verification
A pending or in-service bit that is wrong shows at the ports as a wrong vector or an unexpected 15. It shows no earlier than two edges after the stimulus that caused it: one edge for the bit and one for the output register. A lost in-service bit shows only as lower classes passing too early. The stale bit therefore becomes visible only when a later request of a lower class arrives, or at the end-of-interrupt that should have retired it. Each such sequence is driven, and the output is read after it has had time to settle.

// File: rtl/vec_prio_pkg.sv
package vec_prio_pkg;
  localparam int VEC_W      = 8;
  localparam int NUM_VEC    = 1 << VEC_W;
  localparam int LOW_CNT    = 16;
  localparam int CLASS_W    = VEC_W - $clog2(LOW_CNT);
  localparam int SPUR_VEC   = 15;
  localparam int NMI_VEC    = 2;
  localparam int LEGACY_VEC = 0;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic hit;
    vec_t idx;
  } pick_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setEn;
    vec_t setVec;
    logic ackEn;
    vec_t ackVec;
    logic eoiEn;
  } strobe_t;

  // highest-ranked set bit among the low vectors: NMI, then legacy, then descending
  function automatic pick_t pickLow(input logic [LOW_CNT-1:0] v);
    pick_t res;
    res = '0;
    for (int i = 0; i < LOW_CNT; i++) begin
      if (i != NMI_VEC && i != LEGACY_VEC && i != SPUR_VEC && v[i]) begin
        res.hit = 1'b1;
        res.idx = vec_t'(i);
      end
    end
    if (v[LEGACY_VEC]) begin
      res.hit = 1'b1;
      res.idx = vec_t'(LEGACY_VEC);
    end
    if (v[NMI_VEC]) begin
      res.hit = 1'b1;
      res.idx = vec_t'(NMI_VEC);
    end
    return res;
  endfunction

  // largest set bit at or above LOW_CNT
  function automatic pick_t pickHigh(input logic [NUM_VEC-1:0] v);
    pick_t res;
    res = '0;
    for (int i = LOW_CNT; i < NUM_VEC; i++) begin
      if (v[i]) begin
        res.hit = 1'b1;
        res.idx = vec_t'(i);
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vec_prio_pkg::*;
(
  input  logic    setValid,
  input  vec_t    setVec,
  input  logic    ack,
  input  logic    eoi,
  input  vec_t    curVec,
  output strobe_t strobe
);
  always_comb begin
    strobe.setEn  = setValid && (setVec != vec_t'(SPUR_VEC));
    strobe.setVec = setVec;
    strobe.ackEn  = ack && (curVec != vec_t'(SPUR_VEC));
    strobe.ackVec = curVec;
    strobe.eoiEn  = eoi;
  end
endmodule

// File: rtl/vec_prio_dp.sv
module vec_prio_dp
  import vec_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [CLASS_W-1:0] maskClass,
  output vec_t               curVec
);
  logic [NUM_VEC-1:0] pending, pendingNext;
  logic [NUM_VEC-1:0] inSvc, inSvcNext;
  pick_t pendLow, pendHigh, svcLow, svcHigh;
  logic [CLASS_W-1:0] svcClass, highClass;
  logic eoiAny;
  vec_t eoiVec, nextVec;

  always_comb begin
    pendLow  = pickLow(pending[LOW_CNT-1:0]);
    pendHigh = pickHigh(pending);
    svcLow   = pickLow(inSvc[LOW_CNT-1:0]);
    svcHigh  = pickHigh(inSvc);
    if (svcLow.hit)       svcClass = '1;
    else if (svcHigh.hit) svcClass = svcHigh.idx[VEC_W-1 -: CLASS_W];
    else                  svcClass = '0;
    highClass = pendHigh.idx[VEC_W-1 -: CLASS_W];
    eoiAny    = svcLow.hit || svcHigh.hit;
    eoiVec    = svcLow.hit ? svcLow.idx : svcHigh.idx;
    if (pendLow.hit)
      nextVec = pendLow.idx;
    else if (pendHigh.hit && highClass > maskClass && highClass > svcClass)
      nextVec = pendHigh.idx;
    else
      nextVec = vec_t'(SPUR_VEC);
  end

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
    logic setHit, ackHit, eoiHit;
    assign setHit = strobe.setEn && (strobe.setVec == vec_t'(i));
    assign ackHit = strobe.ackEn && (strobe.ackVec == vec_t'(i));
    assign eoiHit = strobe.eoiEn && eoiAny && (eoiVec == vec_t'(i));
    assign pendingNext[i] = (pending[i] && !ackHit) || setHit;
    assign inSvcNext[i]   = (inSvc[i] && !eoiHit) || ackHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      inSvc   <= '0;
      curVec  <= vec_t'(SPUR_VEC);
    end else begin
      pending <= pendingNext;
      inSvc   <= inSvcNext;
      curVec  <= nextVec;
    end
  end
endmodule

// File: rtl/vec_prio_resolver.sv
module vec_prio_resolver
  import vec_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               setValid,
  input  logic [VEC_W-1:0]   setVec,
  input  logic [CLASS_W-1:0] maskClass,
  input  logic               ack,
  input  logic               eoi,
  output logic [VEC_W-1:0]   curVec
);
  strobe_t strobe;

  vec_prio_ctrl u_ctrl (
    .setValid (setValid),
    .setVec   (setVec),
    .ack      (ack),
    .eoi      (eoi),
    .curVec   (curVec),
    .strobe   (strobe)
  );

  vec_prio_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .maskClass (maskClass),
    .curVec    (curVec)
  );
endmodule

// File: rtl/vec_prio_resolver_chk.sv
module vec_prio_resolver_chk
  import vec_prio_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               setValid,
  input logic [VEC_W-1:0]   setVec,
  input logic [CLASS_W-1:0] maskClass,
  input logic               ack,
  input logic               eoi,
  input logic [VEC_W-1:0]   curVec,
  input logic [NUM_VEC-1:0] pending,
  input logic [NUM_VEC-1:0] inSvc
);
  localparam logic [VEC_W-1:0] SPUR = VEC_W'(SPUR_VEC);
  localparam logic [VEC_W-1:0] NMI  = VEC_W'(NMI_VEC);

  AST_NMI_DELIVERED: assert property (@(posedge clk) disable iff (!rstN)
    (setValid && setVec == NMI) |-> ##2 (curVec == NMI)) else $error("nmi"); // R5

  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ack && curVec == SPUR && !setValid && !eoi) |=> ($stable(pending) && $stable(inSvc))) else $error("ack15"); // R8

  AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    (ack && curVec != SPUR && !(setValid && setVec == curVec))
      |=> (!pending[$past(curVec)] && inSvc[$past(curVec)])) else $error("ackmove"); // R8

  AST_SET_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (ack && curVec != SPUR && setValid && setVec == curVec)
      |=> (pending[$past(curVec)] && inSvc[$past(curVec)])) else $error("setack"); // R9

  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (eoi && !ack && (|inSvc)) |=> ($countones(inSvc) + 1 == $past($countones(inSvc)))) else $error("eoi"); // R10

  AST_HIGH_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (curVec >= VEC_W'(LOW_CNT)) |-> (curVec[VEC_W-1 -: CLASS_W] > $past(maskClass))) else $error("mask"); // R6

  AST_NO_SPUR_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    !pending[SPUR_VEC]) else $error("spur"); // R11
endmodule

bind vec_prio_resolver vec_prio_resolver_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .setValid  (setValid),
  .setVec    (setVec),
  .maskClass (maskClass),
  .ack       (ack),
  .eoi       (eoi),
  .curVec    (curVec),
  .pending   (u_dp.pending),
  .inSvc     (u_dp.inSvc)
);

// File: tb/vec_prio_resolver_bench.sv
module vec_prio_resolver_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setValid = 1'b0;
  logic [7:0] setVec = '0;
  logic [3:0] maskClass = '0;
  logic ack = 1'b0;
  logic eoi = 1'b0;
  logic [7:0] curVec;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  vec_prio_resolver u_vec_prio_resolver (
    .clk(clk), .rstN(rstN), .setValid(setValid), .setVec(setVec),
    .maskClass(maskClass), .ack(ack), .eoi(eoi), .curVec(curVec)
  );

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic [3:0] m;
    logic [7:0] e;
    logic [3:0] req;
  } row_t;
  localparam int ROWS = 10;
  localparam row_t TBL [ROWS] = '{
    '{8'd40,  8'd200, 4'd0,  8'd200, 4'd3},  // R3 larger high wins
    '{8'd5,   8'd250, 4'd0,  8'd5,   4'd2},  // R2 low beats high
    '{8'd14,  8'd0,   4'd0,  8'd0,   4'd4},  // R4 legacy over 14
    '{8'd0,   8'd2,   4'd0,  8'd2,   4'd4},  // R4 nmi over legacy
    '{8'd3,   8'd14,  4'd0,  8'd14,  4'd4},  // R4 descending low
    '{8'd2,   8'd0,   4'd15, 8'd2,   4'd5},  // R5 nmi under full mask
    '{8'h35,  8'h20,  4'd3,  8'd15,  4'd6},  // R6 class equal to mask
    '{8'h45,  8'h20,  4'd3,  8'h45,  4'd6},  // R6 class above mask
    '{8'd15,  8'd15,  4'd0,  8'd15,  4'd11}, // R11 vector 15 ignored
    '{8'd15,  8'h30,  4'd0,  8'h30,  4'd11}  // R11 real request still taken
  };

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input logic [7:0] exp, input string tag);
    checks++;
    if (curVec !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, curVec, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; setValid = 1'b0; ack = 1'b0; eoi = 1'b0; maskClass = '0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic setOne(input logic [7:0] v);
    setValid = 1'b1; setVec = v; tick(); setValid = 1'b0;
  endtask

  task automatic pulseAck(); ack = 1'b1; tick(); ack = 1'b0; endtask
  task automatic pulseEoi(); eoi = 1'b1; tick(); eoi = 1'b0; endtask
  task automatic settle(); tick(); tick(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    check(8'd15, "R1 reset output");

    for (int r = 0; r < ROWS; r++) begin
      doReset();
      maskClass = TBL[r].m;
      setOne(TBL[r].a);
      setOne(TBL[r].b);
      settle();
      check(TBL[r].e, $sformatf("R%0d row %0d", TBL[r].req, r));
    end

    // R12 output latency
    doReset();
    setOne(8'd100);
    check(8'd15, "R12 before output edge");
    tick();
    check(8'd100, "R12 after output edge");

    // R8 ack then R7 in-service blocking, R10 single retire
    pulseAck(); settle();
    check(8'd15, "R8 acked vector leaves pending");
    setOne(8'h50); settle();
    check(8'd15, "R7 lower class blocked by in-service");
    setOne(8'h70); settle();
    check(8'h70, "R7 higher class passes in-service");
    pulseAck(); settle();
    check(8'd15, "R7 both classes now in service");
    pulseEoi(); settle();
    check(8'd15, "R10 only top in-service retired");
    pulseEoi(); settle();
    check(8'h50, "R10 second retire frees lower class");

    // R5 nmi despite in-service and mask
    pulseAck(); maskClass = 4'd15; setOne(8'd2); settle();
    check(8'd2, "R5 nmi with in-service and mask");

    // R8 ack ignored while output is 15
    doReset();
    maskClass = 4'd15;
    setOne(8'h80); settle();
    check(8'd15, "R6 full mask holds high vector");
    pulseAck(); settle();
    maskClass = 4'd0; settle();
    check(8'h80, "R8 ack ignored at 15");

    // R9 set and ack same vector
    doReset();
    setOne(8'h90); settle();
    check(8'h90, "R9 setup");
    ack = 1'b1; setValid = 1'b1; setVec = 8'h90; tick();
    ack = 1'b0; setValid = 1'b0; settle();
    check(8'd15, "R9 in-service class blocks repending vector");
    pulseEoi(); settle();
    check(8'h90, "R9 vector remained pending");

    // R7 low in-service blocks high
    doReset();
    setOne(8'd5); settle();
    pulseAck();
    setOne(8'h30); settle();
    check(8'd15, "R7 low in-service blocks high");
    pulseEoi(); settle();
    check(8'h30, "R10 low retire frees high");

    // R1 reset clears loaded state
    setOne(8'd7); settle();
    doReset(); tick();
    check(8'd15, "R1 reset clears pending");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule